// File: doc/BRIEF.md
# Nearest-Neighbour Image Pyramid Address Generator

This block walks a stored frame as a sequence of progressively smaller images. It does not blend pixels. Each output pixel of a level is the nearest source pixel, so the block only has to produce the linear frame-memory address of that source pixel. The consumer reads the frame memory at that address and gets a stream of scaled images. The first level is the frame at full size. Each later level is 1.2 times smaller than the one before it.

A start pulse latches the frame width and height. From then on, the block emits one address per accepted transfer on a valid/ready handshake. Each address comes with:
- the destination coordinates inside the current level;
- the level index;
- flags marking the last pixel of a row, the last pixel of a level and the last pixel of the whole pyramid.

The walk ends when another level would be shorter than the fixed detection window of 21 rows. With that rule, a 240-row frame yields 14 levels and a 480-row frame yields 18 levels.

Top module: `pyr_scaler`

## Requirements
- R1: While reset is high, and after it is released with no start, `out_valid` and `pyr_done` are low.
- R2: After a start pulse, level 0 is produced first, at factor 1.0. Its first pixel is at x=0, y=0, and pixel (x, y) of level 0 has address y*W + x.
- R3: The scale factor of level k is a fixed-point value with 16 fractional bits. Level 0 is 65536, and each later level is floor((6*f_prev + 2)/5). The source coordinate for destination coordinate d is floor((d*f + 32768) / 65536).
- R4: Pixels leave in raster order with x fastest. The width of a level is the number of d whose source x is at most W-1, and its height is defined the same way against H.
- R5: The address is src_y*W + src_x, where W is the width latched at start.
- R6: Level k+1 follows level k only if k+1 < MAX_LEVELS and level k+1 is at least WIN rows tall. Level 0 is always produced. A 240-row frame yields 14 levels and a 480-row frame yields 18.
- R7: `row_end` is high on the last pixel of each scaled row. `level_end` is high on the last pixel of each level, and `row_end` is always high with it.
- R8: `pyr_done` is high only on the last pixel of the final level. After that pixel is accepted, `out_valid` stays low until the next start.
- R9: While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: A start pulse that arrives while a pyramid is being walked is ignored, and the walk in progress continues unchanged.
- R11: Every source coordinate lies inside the frame, so every address is below W*H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pyramid walk; ignored while busy |
| frame_w | input | CW | Frame width W, latched at start |
| frame_h | input | CW | Frame height H, latched at start |
| out_ready | input | 1 | Consumer accepts the current address |
| mem_addr | output | 2*CW | Linear frame-memory read address |
| out_valid | output | 1 | Address and tags are valid |
| dst_x | output | CW | Column inside the current level |
| dst_y | output | CW | Row inside the current level |
| level | output | $clog2(MAX_LEVELS) | Current level index |
| row_end | output | 1 | Last pixel of a scaled row |
| level_end | output | 1 | Last pixel of a level |
| pyr_done | output | 1 | Last pixel of the final level |

## Verification
The assertions assume the following about the inputs:
- The latched width and height are at least 1, and the height is at least WIN, so that the test for whether another level fits is meaningful.
- The consumer keeps `out_ready` stable across each clock edge.
- Start is only acted on when the block is idle.

The bench drives only frames that meet these assumptions. It changes the inputs on the falling edge. Each run uses one of three handshake patterns: always ready, ready three cycles out of four, and ready one cycle in three. Each run also sends a start pulse with different dimensions partway through the walk, which must have no effect.

// File: rtl/pyr_pkg.sv
package pyr_pkg;

  // Scale factor of level k: 1.2^k in unsigned fixed point with fb fraction bits,
  // rounded at every step.
  function automatic longint unsigned lvl_factor(input int k, input int fb);
    longint unsigned f;
    f = 64'd1 << fb;
    for (int i = 0; i < k; i++) begin
      f = (f * 64'd6 + 64'd2) / 64'd5;
    end
    return f;
  endfunction

  // Source row that destination row (win-1) maps to at level k.
  // The level fits the window when this row is inside the frame.
  function automatic longint unsigned lvl_limit(input int k, input int fb, input int win);
    longint unsigned f;
    f = lvl_factor(k, fb);
    return (longint'(win - 1) * f + (64'd1 << (fb - 1))) >> fb;
  endfunction

endpackage

// File: rtl/pyr_factor_rom.sv
module pyr_factor_rom #(
  parameter int NL  = 24,
  parameter int FB  = 16,
  parameter int FW  = 24,
  parameter int WIN = 21,
  parameter int LW  = 5
) (
  input  logic [LW-1:0] cur_lvl,
  output logic [FW-1:0] fac,
  output logic          nxt_exists,
  output logic [31:0]   limit_nxt
);
  localparam logic [LW-1:0] LAST = LW'(NL - 1);

  logic [FW-1:0] tbl_f [NL];
  logic [31:0]   tbl_l [NL];

  for (genvar g = 0; g < NL; g++) begin : g_tbl
    localparam longint unsigned FV = pyr_pkg::lvl_factor(g, FB);
    localparam longint unsigned LV = pyr_pkg::lvl_limit(g, FB, WIN);
    assign tbl_f[g] = FW'(FV);
    assign tbl_l[g] = 32'(LV);
  end

  logic [LW-1:0] idx_n;
  assign idx_n      = cur_lvl + LW'(1);
  assign nxt_exists = (cur_lvl < LAST);
  assign limit_nxt  = nxt_exists ? tbl_l[idx_n] : '1;
  assign fac        = tbl_f[cur_lvl];

endmodule

// File: rtl/pyr_walker.sv
module pyr_walker #(
  parameter int CW = 12,
  parameter int FB = 16,
  parameter int FW = 24,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] w_in,
  input  logic [CW-1:0] h_in,
  input  logic          adv,
  input  logic [FW-1:0] fac,
  input  logic          nxt_exists,
  input  logic [31:0]   limit_nxt,
  output logic          busy,
  output logic [LW-1:0] lvl,
  output logic [CW-1:0] g_x,
  output logic [CW-1:0] g_y,
  output logic [CW-1:0] g_sx,
  output logic [CW-1:0] g_sy,
  output logic [CW-1:0] w_q,
  output logic          g_eol,
  output logic          g_eolvl,
  output logic          g_last
);
  localparam int AW = CW + FB + 2;
  localparam int SW = AW - FB;
  localparam logic [AW-1:0] HALF = AW'(1) << (FB - 1);

  logic [CW-1:0] h_q;
  logic [AW-1:0] ax, ay, facx;
  logic [SW-1:0] sx_raw, sy_raw, nx_src, ny_src, w_ext, h_ext;
  logic          nxt_ok;

  assign facx   = AW'(fac);
  assign w_ext  = SW'(w_q);
  assign h_ext  = SW'(h_q);
  assign sx_raw = SW'((ax + HALF) >> FB);
  assign sy_raw = SW'((ay + HALF) >> FB);
  assign nx_src = SW'((ax + facx + HALF) >> FB);
  assign ny_src = SW'((ay + facx + HALF) >> FB);

  assign g_eol   = (nx_src >= w_ext);
  assign g_eolvl = g_eol && (ny_src >= h_ext);
  assign nxt_ok  = nxt_exists && (limit_nxt < 32'(h_q));
  assign g_last  = g_eolvl && !nxt_ok;

  // clamp to the frame edge
  assign g_sx = (sx_raw >= w_ext) ? (w_q - CW'(1)) : sx_raw[CW-1:0];
  assign g_sy = (sy_raw >= h_ext) ? (h_q - CW'(1)) : sy_raw[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      lvl  <= '0;
      g_x  <= '0;
      g_y  <= '0;
      ax   <= '0;
      ay   <= '0;
      w_q  <= '0;
      h_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        w_q  <= w_in;
        h_q  <= h_in;
        lvl  <= '0;
        g_x  <= '0;
        g_y  <= '0;
        ax   <= '0;
        ay   <= '0;
      end
    end else if (adv) begin
      if (!g_eol) begin
        g_x <= g_x + CW'(1);
        ax  <= ax + facx;
      end else begin
        g_x <= '0;
        ax  <= '0;
        if (!g_eolvl) begin
          g_y <= g_y + CW'(1);
          ay  <= ay + facx;
        end else begin
          g_y <= '0;
          ay  <= '0;
          if (nxt_ok) lvl  <= lvl + LW'(1);
          else        busy <= 1'b0;
        end
      end
    end
  end

  // R11: the row and column walk never leaves the frame, even before the clamp
  a_r11_src_inside: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sx_raw < w_ext) && (sy_raw < h_ext));

  // R2: every walk begins at the top-left pixel of level 0
  a_r2_level0_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (lvl == '0) && (g_x == '0) && (g_y == '0));

  // R10: a start pulse while busy leaves the latched dimensions alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(w_q) && $stable(h_q));

endmodule

// File: rtl/pyr_addr_pipe.sv
module pyr_addr_pipe #(
  parameter int CW = 12,
  parameter int LW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ready,
  input  logic            g_valid,
  input  logic [CW-1:0]   g_x,
  input  logic [CW-1:0]   g_y,
  input  logic [CW-1:0]   g_sx,
  input  logic [CW-1:0]   g_sy,
  input  logic [CW-1:0]   g_w,
  input  logic [LW-1:0]   g_lvl,
  input  logic            g_eol,
  input  logic            g_eolvl,
  input  logic            g_last,
  output logic            adv,
  output logic            o_valid,
  output logic [2*CW-1:0] o_addr,
  output logic [CW-1:0]   o_x,
  output logic [CW-1:0]   o_y,
  output logic [LW-1:0]   o_lvl,
  output logic            o_eol,
  output logic            o_eolvl,
  output logic            o_done
);
  localparam int PW = 2 * CW;

  logic          s1_v, s1_eol, s1_eolvl, s1_last;
  logic [CW-1:0] s1_x, s1_y, s1_sx, s1_sy, s1_w;
  logic [LW-1:0] s1_lvl;
  logic          adv2;

  assign adv2 = !o_valid || ready;
  assign adv  = !s1_v || adv2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_eol   <= 1'b0;
      s1_eolvl <= 1'b0;
      s1_last  <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_sx    <= '0;
      s1_sy    <= '0;
      s1_w     <= '0;
      s1_lvl   <= '0;
    end else if (adv) begin
      s1_v     <= g_valid;
      s1_eol   <= g_valid && g_eol;
      s1_eolvl <= g_valid && g_eolvl;
      s1_last  <= g_valid && g_last;
      s1_x     <= g_x;
      s1_y     <= g_y;
      s1_sx    <= g_sx;
      s1_sy    <= g_sy;
      s1_w     <= g_w;
      s1_lvl   <= g_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_addr  <= '0;
      o_x     <= '0;
      o_y     <= '0;
      o_lvl   <= '0;
      o_eol   <= 1'b0;
      o_eolvl <= 1'b0;
      o_done  <= 1'b0;
    end else if (adv2) begin
      o_valid <= s1_v;
      o_addr  <= PW'(s1_sy) * PW'(s1_w) + PW'(s1_sx);
      o_x     <= s1_x;
      o_y     <= s1_y;
      o_lvl   <= s1_lvl;
      o_eol   <= s1_eol;
      o_eolvl <= s1_eolvl;
      o_done  <= s1_last;
    end
  end

  // R9: a stalled transfer holds all of its fields
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    o_valid && !ready |=> o_valid && $stable(o_addr) && $stable(o_x) && $stable(o_y)
                          && $stable(o_lvl) && $stable(o_eol) && $stable(o_done));

  // R7: the end of a level is also the end of a row
  a_r7_level_end_row_end: assert property (@(posedge clk) disable iff (rst)
    o_valid && o_eolvl |-> o_eol);

  // R8: the pyramid ends only on the end of a level
  a_r8_done_on_level_end: assert property (@(posedge clk) disable iff (rst)
    o_valid && o_done |-> o_eolvl);

endmodule

// File: rtl/pyr_scaler.sv
module pyr_scaler #(
  parameter int CW         = 12,
  parameter int FB         = 16,
  parameter int FW         = 24,
  parameter int MAX_LEVELS = 24,
  parameter int WIN        = 21
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [CW-1:0]                 frame_w,
  input  logic [CW-1:0]                 frame_h,
  input  logic                          out_ready,
  output logic [2*CW-1:0]               mem_addr,
  output logic                          out_valid,
  output logic [CW-1:0]                 dst_x,
  output logic [CW-1:0]                 dst_y,
  output logic [$clog2(MAX_LEVELS)-1:0] level,
  output logic                          row_end,
  output logic                          level_end,
  output logic                          pyr_done
);
  localparam int LW = $clog2(MAX_LEVELS);

  logic          busy, adv, nxt_exists, eol, eolvl, last;
  logic [LW-1:0] lvl;
  logic [FW-1:0] fac;
  logic [31:0]   limit_nxt;
  logic [CW-1:0] gx, gy, gsx, gsy, wq;

  pyr_factor_rom #(.NL(MAX_LEVELS), .FB(FB), .FW(FW), .WIN(WIN), .LW(LW)) u_rom (
    .cur_lvl(lvl), .fac(fac), .nxt_exists(nxt_exists), .limit_nxt(limit_nxt)
  );

  pyr_walker #(.CW(CW), .FB(FB), .FW(FW), .LW(LW)) u_walk (
    .clk(clk), .rst(rst), .start(start), .w_in(frame_w), .h_in(frame_h),
    .adv(adv), .fac(fac), .nxt_exists(nxt_exists), .limit_nxt(limit_nxt),
    .busy(busy), .lvl(lvl), .g_x(gx), .g_y(gy), .g_sx(gsx), .g_sy(gsy),
    .w_q(wq), .g_eol(eol), .g_eolvl(eolvl), .g_last(last)
  );

  pyr_addr_pipe #(.CW(CW), .LW(LW)) u_pipe (
    .clk(clk), .rst(rst), .ready(out_ready), .g_valid(busy),
    .g_x(gx), .g_y(gy), .g_sx(gsx), .g_sy(gsy), .g_w(wq), .g_lvl(lvl),
    .g_eol(eol), .g_eolvl(eolvl), .g_last(last), .adv(adv),
    .o_valid(out_valid), .o_addr(mem_addr), .o_x(dst_x), .o_y(dst_y),
    .o_lvl(level), .o_eol(row_end), .o_eolvl(level_end), .o_done(pyr_done)
  );

endmodule

// File: tb/tb_pyr_scaler.sv
module tb_pyr_scaler;
  localparam int CW = 12, FB = 16, NL = 24, WIN = 21;
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0, out_ready = 1'b0;
  logic [CW-1:0] frame_w = '0, frame_h = '0;
  logic [2*CW-1:0] mem_addr;
  logic          out_valid, row_end, level_end, pyr_done;
  logic [CW-1:0] dst_x, dst_y;
  logic [LW-1:0] level;

  int checks = 0, failures = 0;

  pyr_scaler #(.CW(CW), .FB(FB), .MAX_LEVELS(NL), .WIN(WIN)) dut (
    .clk(clk), .rst(rst), .start(start), .frame_w(frame_w), .frame_h(frame_h),
    .out_ready(out_ready), .mem_addr(mem_addr), .out_valid(out_valid),
    .dst_x(dst_x), .dst_y(dst_y), .level(level), .row_end(row_end),
    .level_end(level_end), .pyr_done(pyr_done)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint fac_of(input int k);
    longint f = 65536;
    for (int i = 0; i < k; i++) f = (6 * f + 2) / 5;
    return f;
  endfunction

  function automatic longint src_of(input longint d, input longint f);
    return (d * f + 32768) / 65536;
  endfunction

  function automatic int dim_of(input int k, input int n);
    int c = 0;
    longint f = fac_of(k);
    while (src_of(c, f) <= n - 1) c++;
    return c;
  endfunction

  function automatic int levels_of(input int h);
    int k = 1;
    while (k < NL && dim_of(k, h) >= WIN) k++;
    return k;
  endfunction

  task automatic run_frame(input int w, input int h, input int exp_lv, input int rmode);
    int lv = 0, ex = 0, ey = 0, ends = 0, n = 0;
    int nw, nh, total;
    longint f, sx, sy, eaddr;
    bit fin = 0, pv_stall = 0, eol_e, eolvl_e, last_e;
    logic [2*CW-1:0] paddr = '0;
    logic [CW-1:0] px = '0, py = '0;
    logic [LW-1:0] plev = '0;
    nw = dim_of(0, w); nh = dim_of(0, h); total = levels_of(h); f = fac_of(0);
    if (exp_lv > 0) chk(total == exp_lv, "R6 level count for height", total, exp_lv);
    while (!fin && n < 150000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin frame_w = CW'(w); frame_h = CW'(h); end
      if (n == 40) begin frame_w = CW'(w + 7); frame_h = CW'(h + 5); end  // R10 ignored start
      start = (n == 1) || (n == 40);
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (n % 4) != 3;
        default: out_ready = (n % 3) == 0;
      endcase
      #1;
      if (pv_stall)
        chk(out_valid && mem_addr == paddr && dst_x == px && dst_y == py && level == plev,
            "R9 hold while stalled", longint'(mem_addr), longint'(paddr));
      if (out_valid && out_ready) begin
        sx = src_of(ex, f); sy = src_of(ey, f); eaddr = sy * w + sx;
        chk(longint'(mem_addr) == eaddr, (lv == 0) ? "R2 R5 level0 address" : "R3 R5 scaled address",
            longint'(mem_addr), eaddr);
        chk(dst_x == CW'(ex) && dst_y == CW'(ey) && level == LW'(lv), "R4 raster coordinates",
            longint'(level) * 100000000 + longint'(dst_y) * 10000 + dst_x,
            longint'(lv) * 100000000 + longint'(ey) * 10000 + ex);
        eol_e = (ex == nw - 1); eolvl_e = eol_e && (ey == nh - 1); last_e = eolvl_e && (lv == total - 1);
        chk(row_end == eol_e && level_end == eolvl_e, "R7 row and level end flags",
            {row_end, level_end}, {eol_e, eolvl_e});
        chk(pyr_done == last_e, "R8 done flag", pyr_done, last_e);
        chk(longint'(mem_addr) < longint'(w) * h, "R11 address inside frame", longint'(mem_addr), longint'(w) * h);
        if (!eol_e) ex++;
        else begin
          ex = 0;
          if (!eolvl_e) ey++;
          else begin
            ey = 0; ends++;
            if (last_e) fin = 1;
            else begin
              lv++; f = fac_of(lv); nw = dim_of(lv, w); nh = dim_of(lv, h);
            end
          end
        end
      end
      pv_stall = out_valid && !out_ready;
      paddr = mem_addr; px = dst_x; py = dst_y; plev = level;
    end
    start = 1'b0;
    chk(fin, "R8 pyramid completed", fin, 1);
    chk(ends == total, "R6 levels emitted", ends, total);
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk(!out_valid && !pyr_done, "R8 idle after final pixel", out_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !pyr_done, "R1 outputs low in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid && !pyr_done, "R1 idle without start", out_valid, 0);
    run_frame(40, 30, 3, 1);
    run_frame(64, 48, 0, 2);
    run_frame(33, 21, 1, 0);
    run_frame(21, 240, 14, 0);
    run_frame(22, 480, 18, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule